// File: doc/BRIEF.md
# Storage Card Host Register Decoder

This block sits at the device side of a removable-storage host port. It decodes sampled host strobes, chip selects and address bits into one-hot register selects and byte-lane steering. The same decoder serves two personalities. In the disk personality, two chip selects pick a task-file register or the control block, and a DMA acknowledge forces word-wide transfers. In the card personality, two card enables and address bit 0 steer bytes for 8-bit and 16-bit hosts, and a region pin separates attribute, common and I/O space.

The personality and the master/slave role are read from strap pins once, on the first clock after reset is released. They then stay fixed until the next reset. Every decoded output is registered, so a result appears one clock after the inputs that cause it.

Top module: `cf_regsel`

## Requirements
- R1: On the first clock after reset release, `ide_mode` latches 1 if `oe_atasel_n` is low and 0 otherwise. It holds that value until the next reset.
- R2: In disk personality, `tf_sel` has exactly bit `addr[2:0]` set when all of the following hold: `sel0_n` is low, `sel1_n` is high, `reg_dmack_n` is high, and `iord_n` or `iowr_n` is low. Otherwise `tf_sel` is zero. `addr[10:3]` has no effect.
- R3: In disk personality, `alt_sel` is set on a read and `dc_sel` on a write when all of the following hold: `sel1_n` is low, `sel0_n` is high, `reg_dmack_n` is high and `addr[2:0]` is 6.
- R4: In disk personality, an access to task-file register 0 enables both lanes (`lane_lo`, `lane_hi`). Any other task-file, alternate-status or device-control access enables `lane_lo` only. `lane_swap` stays 0.
- R5: In disk personality, `dma_sel` and both lanes are set when `reg_dmack_n` is low, both chip selects are high, and a read or write strobe is low. With no strobe, a low `reg_dmack_n` selects nothing.
- R6: `iocs16_n` is low in disk personality whenever one of two decodes holds: (a) `sel0_n` alone is low with `addr[2:0]`=0, or (b) `reg_dmack_n` alone is low. Strobes do not affect it. It is always high in card personality.
- R7: In disk personality, two conditions are protocol violations: both chip selects low, or either chip select low together with a low `reg_dmack_n`. A violation produces no select and no lane. It sets `proto_err`, which stays set until reset.
- R8: `is_master` latches 1 only when the disk personality is latched and `csel_n` is low at that same clock. It is 0 in card personality.
- R9: In card personality, during any strobe with a card enable low: `lane_lo` follows `sel0_n` low and `lane_hi` follows `sel1_n` low. `lane_swap` is 1 when `sel0_n` alone is low and `addr[0]`=1, which places the odd byte on the low lane.
- R10: In card personality, with a card enable low, the selects are decoded as follows. A memory cycle (`oe_atasel_n` or `we_n` low) sets `attr_sel` when `reg_dmack_n` is low and `common_sel` when it is high. An I/O cycle (`iord_n` or `iowr_n` low) with `reg_dmack_n` low sets `io_sel`.
- R11: `wr_stb` pulses for one clock on the clock after `iowr_n` is first seen high, provided the previous clock decoded a task-file or device-control write.
- R12: `reg_addr` equals `addr` in card personality and `addr[2:0]` zero-extended in disk personality.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel0_n | input | 1 | Chip select 0 / card enable, even byte |
| sel1_n | input | 1 | Chip select 1 / card enable, odd byte |
| addr | input | 11 | Host address |
| reg_dmack_n | input | 1 | Region select (card) / DMA acknowledge (disk) |
| iord_n | input | 1 | I/O read strobe |
| iowr_n | input | 1 | I/O write strobe |
| oe_atasel_n | input | 1 | Output enable (card) / personality strap |
| we_n | input | 1 | Memory write strobe |
| csel_n | input | 1 | Master/slave strap, low means master |
| ide_mode | output | 1 | Latched disk personality |
| is_master | output | 1 | Latched master role |
| tf_sel | output | 8 | One-hot task-file register select |
| alt_sel | output | 1 | Alternate status read select |
| dc_sel | output | 1 | Device control write select |
| dma_sel | output | 1 | DMA data transfer |
| attr_sel | output | 1 | Attribute memory cycle |
| common_sel | output | 1 | Common memory cycle |
| io_sel | output | 1 | Card I/O cycle |
| lane_lo | output | 1 | Low byte lane enabled |
| lane_hi | output | 1 | High byte lane enabled |
| lane_swap | output | 1 | Odd byte routed to low lane |
| iocs16_n | output | 1 | Word transfer expected, active low |
| proto_err | output | 1 | Sticky protocol violation |
| wr_stb | output | 1 | Write capture pulse |
| reg_addr | output | 11 | Decoded register address |

## Verification
Every select, lane, address and error output is due at the first rising edge after the inputs are applied. The bench drives each input pattern on a falling edge and compares on the next falling edge. `wr_stb` depends on two successive samples, so it is due one edge after `iowr_n` returns high. The bench model tracks the previous cycle's write decode to predict it. The straps are applied before reset release and two clocks are skipped before the personality is compared.

// File: rtl/cf_regsel.sv
module cf_regsel #(
  parameter int ADDR_W  = 11,
  parameter int NUM_TF  = 8,
  parameter int ALT_IDX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel0_n,
  input  logic              sel1_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              reg_dmack_n,
  input  logic              iord_n,
  input  logic              iowr_n,
  input  logic              oe_atasel_n,
  input  logic              we_n,
  input  logic              csel_n,
  output logic              ide_mode,
  output logic              is_master,
  output logic [NUM_TF-1:0] tf_sel,
  output logic              alt_sel,
  output logic              dc_sel,
  output logic              dma_sel,
  output logic              attr_sel,
  output logic              common_sel,
  output logic              io_sel,
  output logic              lane_lo,
  output logic              lane_hi,
  output logic              lane_swap,
  output logic              iocs16_n,
  output logic              proto_err,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] reg_addr
);
  localparam int TF_W = $clog2(NUM_TF);

  logic straps_done, wsel_q;
  logic c0, c1, dk, rd, wr, viol;
  logic tf_ok, cs1_ok, dma_ok, tf_hit, data_reg;
  logic alt_d, dc_d, dma_d, word_d, byte_d;
  logic any_ce, mem_cyc, io_cyc, pc_act;
  logic [TF_W-1:0] idx;
  logic [NUM_TF-1:0] tf_d;

  assign c0  = ~sel0_n;
  assign c1  = ~sel1_n;
  assign dk  = ~reg_dmack_n;
  assign rd  = ~iord_n;
  assign wr  = ~iowr_n;
  assign idx = addr[TF_W-1:0];

  assign viol     = (c0 & c1) | ((c0 | c1) & dk);
  assign tf_ok    = c0 & ~c1 & ~dk;
  assign cs1_ok   = c1 & ~c0 & ~dk & (idx == TF_W'(ALT_IDX));
  assign dma_ok   = dk & ~c0 & ~c1;
  assign tf_hit   = tf_ok & (rd | wr);
  assign data_reg = tf_ok & (idx == '0);
  assign alt_d    = cs1_ok & rd;
  assign dc_d     = cs1_ok & wr;
  assign dma_d    = dma_ok & (rd | wr);
  assign word_d   = (tf_hit & data_reg) | dma_d;
  assign byte_d   = (tf_hit & ~data_reg) | alt_d | dc_d;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TF; gi++) begin : g_tf
      assign tf_d[gi] = tf_hit & (idx == TF_W'(gi));
    end
  endgenerate

  assign any_ce  = c0 | c1;
  assign mem_cyc = ~oe_atasel_n | ~we_n;
  assign io_cyc  = rd | wr;
  assign pc_act  = any_ce & (mem_cyc | io_cyc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      straps_done <= 1'b0;
      ide_mode    <= 1'b0;
      is_master   <= 1'b0;
    end else if (!straps_done) begin
      straps_done <= 1'b1;
      ide_mode    <= ~oe_atasel_n;
      is_master   <= ~oe_atasel_n & ~csel_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tf_sel     <= '0;
      alt_sel    <= 1'b0;
      dc_sel     <= 1'b0;
      dma_sel    <= 1'b0;
      attr_sel   <= 1'b0;
      common_sel <= 1'b0;
      io_sel     <= 1'b0;
      lane_lo    <= 1'b0;
      lane_hi    <= 1'b0;
      lane_swap  <= 1'b0;
      iocs16_n   <= 1'b1;
      proto_err  <= 1'b0;
      wsel_q     <= 1'b0;
      wr_stb     <= 1'b0;
      reg_addr   <= '0;
    end else if (ide_mode) begin
      tf_sel     <= tf_d;
      alt_sel    <= alt_d;
      dc_sel     <= dc_d;
      dma_sel    <= dma_d;
      attr_sel   <= 1'b0;
      common_sel <= 1'b0;
      io_sel     <= 1'b0;
      lane_lo    <= word_d | byte_d;
      lane_hi    <= word_d;
      lane_swap  <= 1'b0;
      iocs16_n   <= ~(data_reg | dma_ok);
      proto_err  <= proto_err | viol;
      wsel_q     <= (tf_ok | cs1_ok) & wr;
      wr_stb     <= wsel_q & iowr_n;
      reg_addr   <= ADDR_W'(idx);
    end else begin
      tf_sel     <= '0;
      alt_sel    <= 1'b0;
      dc_sel     <= 1'b0;
      dma_sel    <= 1'b0;
      attr_sel   <= any_ce & mem_cyc & dk;
      common_sel <= any_ce & mem_cyc & ~dk;
      io_sel     <= any_ce & io_cyc & dk;
      lane_lo    <= pc_act & c0;
      lane_hi    <= pc_act & c1;
      lane_swap  <= pc_act & c0 & ~c1 & addr[0];
      iocs16_n   <= 1'b1;
      wsel_q     <= 1'b0;
      wr_stb     <= 1'b0;
      reg_addr   <= addr;
    end
  end
endmodule

module cf_regsel_chk #(
  parameter int NUM_TF = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel0_n,
  input logic              sel1_n,
  input logic              reg_dmack_n,
  input logic              iowr_n,
  input logic              ide_mode,
  input logic              is_master,
  input logic [NUM_TF-1:0] tf_sel,
  input logic              alt_sel,
  input logic              dc_sel,
  input logic              dma_sel,
  input logic              iocs16_n,
  input logic              proto_err,
  input logic              wr_stb
);
  AST_TF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tf_sel)); // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(rst_n, 2) |-> $stable(ide_mode) && $stable(is_master)); // R1
  AST_MASTER_IDE: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> ide_mode); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R7
  AST_VIOL_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ide_mode && !sel0_n && !sel1_n |=> tf_sel == '0 && !alt_sel && !dc_sel && !dma_sel && proto_err); // R7
  AST_DMA_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ide_mode && !reg_dmack_n && !sel0_n |=> tf_sel == '0 && !dma_sel); // R5
  AST_IOCS16_CARD: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_mode |-> iocs16_n); // R6
  AST_WR_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(iowr_n) && !$past(iowr_n, 2)); // R11
endmodule

bind cf_regsel cf_regsel_chk #(.NUM_TF(NUM_TF)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1_n(sel1_n),
  .reg_dmack_n(reg_dmack_n), .iowr_n(iowr_n), .ide_mode(ide_mode),
  .is_master(is_master), .tf_sel(tf_sel), .alt_sel(alt_sel), .dc_sel(dc_sel),
  .dma_sel(dma_sel), .iocs16_n(iocs16_n), .proto_err(proto_err), .wr_stb(wr_stb)
);

// File: tb/cf_regsel_bench.sv
module cf_regsel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel0_n = 1, sel1_n = 1, reg_dmack_n = 1, iord_n = 1, iowr_n = 1;
  logic oe_atasel_n = 1, we_n = 1, csel_n = 1;
  logic [10:0] addr = '0;
  logic ide_mode, is_master, alt_sel, dc_sel, dma_sel, attr_sel, common_sel, io_sel;
  logic lane_lo, lane_hi, lane_swap, iocs16_n, proto_err, wr_stb;
  logic [7:0] tf_sel;
  logic [10:0] reg_addr;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit m_ide = 0, m_err = 0, m_wsel = 0;

  always #5 clk = ~clk;

  cf_regsel u_cf_regsel (
    .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1_n(sel1_n), .addr(addr),
    .reg_dmack_n(reg_dmack_n), .iord_n(iord_n), .iowr_n(iowr_n),
    .oe_atasel_n(oe_atasel_n), .we_n(we_n), .csel_n(csel_n),
    .ide_mode(ide_mode), .is_master(is_master), .tf_sel(tf_sel),
    .alt_sel(alt_sel), .dc_sel(dc_sel), .dma_sel(dma_sel), .attr_sel(attr_sel),
    .common_sel(common_sel), .io_sel(io_sel), .lane_lo(lane_lo),
    .lane_hi(lane_hi), .lane_swap(lane_swap), .iocs16_n(iocs16_n),
    .proto_err(proto_err), .wr_stb(wr_stb), .reg_addr(reg_addr)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_tf(input bit s0, s1, dk, rd, wr, input logic [10:0] a);
    if (!s0 && s1 && dk && (!rd || !wr)) return 8'(1) << a[2:0];
    return 8'h0;
  endfunction

  task automatic step(input bit s0, s1, dk, rd, wr, oe, we, input logic [10:0] a);
    bit c0, c1, k, r, w, tfok, cs1ok, dmaok, tfhit, dreg, word, byt, anyce, mem, io, act, viol;
    sel0_n = s0; sel1_n = s1; reg_dmack_n = dk; iord_n = rd; iowr_n = wr;
    oe_atasel_n = oe; we_n = we; addr = a;
    @(negedge clk);
    c0 = !s0; c1 = !s1; k = !dk; r = !rd; w = !wr;
    if (m_ide) begin
      viol  = (c0 && c1) || ((c0 || c1) && k);
      tfok  = c0 && !c1 && !k;
      cs1ok = c1 && !c0 && !k && a[2:0] == 3'd6;
      dmaok = k && !c0 && !c1;
      tfhit = tfok && (r || w);
      dreg  = tfok && a[2:0] == 3'd0;
      word  = (tfhit && dreg) || (dmaok && (r || w));
      byt   = (tfhit && !dreg) || (cs1ok && (r || w));
      m_err = m_err || viol;
      check("R2 tf_sel", 32'(tf_sel), 32'(exp_tf(s0, s1, dk, rd, wr, a)));
      check("R3 alt/dc", {alt_sel, dc_sel}, {cs1ok && r, cs1ok && w});
      check("R4 lanes", {lane_lo, lane_hi, lane_swap}, {word || byt, word, 1'b0});
      check("R5 dma_sel", 32'(dma_sel), 32'(dmaok && (r || w)));
      check("R6 iocs16_n", 32'(iocs16_n), 32'(!(dreg || dmaok)));
      check("R7 proto_err", 32'(proto_err), 32'(m_err));
      check("R11 wr_stb", 32'(wr_stb), 32'(m_wsel && wr));
      check("R12 reg_addr", 32'(reg_addr), 32'(a[2:0]));
      check("R10 card sel off", {attr_sel, common_sel, io_sel}, 3'b000);
      m_wsel = (tfok || cs1ok) && w;
    end else begin
      anyce = c0 || c1; mem = !oe || !we; io = r || w; act = anyce && (mem || io);
      check("R9 lanes", {lane_lo, lane_hi, lane_swap}, {act && c0, act && c1, act && c0 && !c1 && a[0]});
      check("R10 selects", {attr_sel, common_sel, io_sel},
            {anyce && mem && k, anyce && mem && !k, anyce && io && k});
      check("R6 iocs16_n card", 32'(iocs16_n), 32'd1);
      check("R2 tf_sel card", 32'({tf_sel, alt_sel, dc_sel, dma_sel, wr_stb}), 32'd0);
      check("R12 reg_addr card", 32'(reg_addr), 32'(a));
    end
  endtask

  task automatic do_reset(input bit oe, input bit cs);
    @(negedge clk);
    rst_n = 0; oe_atasel_n = oe; csel_n = cs;
    sel0_n = 1; sel1_n = 1; reg_dmack_n = 1; iord_n = 1; iowr_n = 1; we_n = 1;
    @(negedge clk);
    check("R1 reset ide_mode", 32'(ide_mode), 32'd0);
    check("R7 reset proto_err", 32'(proto_err), 32'd0);
    check("R6 reset iocs16_n", 32'(iocs16_n), 32'd1);
    check("R2 reset tf_sel", 32'(tf_sel), 32'd0);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    m_ide = !oe; m_err = 0; m_wsel = 0;
    check("R1 ide_mode", 32'(ide_mode), 32'(!oe));
    check("R8 is_master", 32'(is_master), 32'(!oe && !cs));
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C5E));
    do_reset(1'b0, 1'b0);
    // R2 every register, R12 high address bits ignored
    for (int i = 0; i < 8; i++) step(0, 1, 1, 0, 1, 0, 1, {8'hA5, 3'(i)});
    step(1, 0, 1, 0, 1, 0, 1, 11'h7FE);            // R3 alt status read
    step(1, 0, 1, 1, 0, 0, 1, 11'h006);            // R3 device control write
    step(1, 0, 1, 0, 1, 0, 1, 11'h005);            // R3 wrong offset
    step(1, 1, 0, 0, 1, 0, 1, 11'h000);            // R5 dma read
    step(1, 1, 0, 1, 1, 0, 1, 11'h000);            // R5 dmack without strobe, R6
    step(0, 1, 1, 1, 1, 0, 1, 11'h000);            // R6 data reg decoded, no strobe
    step(0, 1, 1, 1, 0, 0, 1, 11'h003);            // R11 write low
    step(0, 1, 1, 1, 1, 0, 1, 11'h003);            // R11 release -> pulse
    step(1, 1, 1, 1, 1, 0, 1, 11'h003);            // R11 single pulse
    for (int i = 0; i < 300; i++) begin
      int k = $urandom_range(0, 9);
      bit rw = $urandom_range(0, 1);
      logic [10:0] a = 11'($urandom);
      case (k)
        0, 1, 2: step(0, 1, 1, rw, !rw, 0, 1, a);
        3:       step(1, 0, 1, rw, !rw, 0, 1, {a[10:3], 3'd6});
        4:       step(1, 1, 0, rw, !rw, 0, 1, a);
        5:       step(1, 1, 0, 1, 1, 0, 1, a);
        6:       step(0, 1, 1, 1, 1, 0, 1, a);
        default: step(1, 1, 1, 1, 1, 0, 1, a);
      endcase
    end
    step(0, 0, 1, 0, 1, 0, 1, 11'h001);            // R7 both selects
    step(0, 1, 1, 0, 1, 0, 1, 11'h001);            // R7 sticky after clean access
    do_reset(1'b0, 1'b1);                          // R8 slave
    step(0, 1, 0, 0, 1, 0, 1, 11'h000);            // R7 cs0 with dmack
    do_reset(1'b1, 1'b0);                          // R1 card, R8 csel ignored
    step(0, 0, 1, 1, 1, 0, 1, 11'h123);            // R9 word, R10 common
    step(0, 1, 1, 1, 1, 0, 1, 11'h001);            // R9 odd byte on low lane
    step(1, 0, 0, 1, 1, 1, 0, 11'h001);            // R9 high lane, R10 attr write
    step(0, 1, 0, 0, 1, 1, 1, 11'h000);            // R10 io read
    for (int i = 0; i < 300; i++) begin
      int k = $urandom_range(0, 3);
      logic [10:0] a = 11'($urandom);
      bit s0 = $urandom_range(0, 1), s1 = $urandom_range(0, 1), rg = $urandom_range(0, 1);
      case (k)
        0: step(s0, s1, rg, 1, 1, 0, 1, a);
        1: step(s0, s1, rg, 1, 1, 1, 0, a);
        2: step(s0, s1, rg, 0, 1, 1, 1, a);
        default: step(s0, s1, rg, 1, 0, 1, 1, a);
      endcase
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule